// File: doc/BRIEF.md
# Single-Character SPI Master with Register Port

This block is an SPI master driven through a small synchronous register port. Software programs a control word with the character length, the bit order, the SCLK divider, loopback and the run controls. It then writes one character to the transmit location. The block moves that character into its shift register and clocks it out on `mosi`. On the same clock edges it samples `miso` and assembles the received character, right-justified.

Two sticky event flags report progress. One says that a received character is waiting. The other says that the transmit holding slot is free again. Each flag clears when software writes a 1 to it. A mask register selects which flags drive the single interrupt line. The character length is held in a 4-bit code and can only be changed while the interface is stopped. Software therefore stops the interface, sets the length, and restarts it before each character.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control word reads 0, the event word reads 0x100 (slot-free set, receive flag clear), the mask reads 0, and `irq`, `sclk` and `mosi` are low.
- R2: Register word addresses are 0 control, 1 events, 2 mask, 3 transmit, 4 receive. Control bits: 30 loopback, 26 MSB-first, 25 master, 24 enable, 23:20 length code, 19:16 divider. All other control bits read 0, and the transmit address reads 0.
- R3: Length code 0 gives 32-bit characters, codes 3 to 15 give code+1 bits, and codes 1 and 2 give 4 bits. Exactly that many SCLK rising edges occur per character.
- R4: A control write made while enable (bit 24) is set leaves the length code unchanged but updates the other fields.
- R5: A character written while enable or master is clear waits in the holding slot with no SCLK activity. It is sent once both bits are set.
- R6: SCLK idles low. Each SCLK half period lasts DIV_UNIT × d system clocks, where d is the divider field and a field value of 0 counts as 16. `mosi` changes only while SCLK is low, and `miso` is sampled on the rising edge.
- R7: Transmit data is taken from the low bits of the transmit word. With bit 26 set the highest of those bits goes first; with it clear bit 0 goes first. Bits above the character length are ignored.
- R8: The received character reads back right-justified with the upper bits zero. With MSB-first order the first bit sampled lands in the top position, otherwise in bit 0. The receive flag (event bit 9) sets after the last sample.
- R9: In loopback the receiver samples the block's own `mosi`, and the `miso` pin has no effect.
- R10: The slot-free flag (event bit 8) clears on a transmit write and sets when the held character moves into the shifter.
- R11: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R12: `irq` is high while any event bit is set whose mask bit (9 or 8 of the mask word) is set. Only mask bits 9 and 8 are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with DIV_UNIT set to 1, so a divider field of d gives SCLK half periods of exactly d system clocks. This keeps 32-bit characters short. It also lets the bench measure the half period directly for a mid-range divider and for the zero-means-sixteen case. With such short characters, each length code class (32 bits, clamped short lengths, mid lengths, the 16-bit maximum of the 4-bit field) can be run in both bit orders and in loopback. A slow divider holds one character in flight long enough to observe the holding slot filling and draining.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = $clog2(WORD_W) + 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_EVT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RX   = 3'd4;

  localparam int B_LOOP = 30;
  localparam int B_MSBF = 26;
  localparam int B_MAST = 25;
  localparam int B_RUN  = 24;
  localparam int B_LEN  = 20;
  localparam int B_DIV  = 16;
  localparam int E_RXF  = 9;
  localparam int E_SLOT = 8;

  typedef struct packed {
    logic       loop;
    logic       msbf;
    logic       mast;
    logic       run;
    logic [3:0] lcode;
    logic [3:0] div;
  } ctrl_t;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_st_e;

  function automatic logic [LEN_W-1:0] code_to_len(input logic [3:0] code);
    if (code == 4'd0)      return LEN_W'(WORD_W);
    else if (code < 4'd3)  return LEN_W'(4);
    else                   return LEN_W'(code) + LEN_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] flip_word(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = d[WORD_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer
  import spi_ctl_pkg::*;
#(
  parameter int DIV_UNIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [3:0] div_i,
  output logic       tick_o
);
  localparam int CW = $clog2(DIV_UNIT * 16 + 1);

  logic [CW-1:0] cnt_q, cnt_d, half_c;

  always_comb begin
    half_c = CW'(DIV_UNIT) * ((div_i == 4'd0) ? CW'(16) : CW'(div_i));
    tick_o = run_i && (cnt_q >= half_c - CW'(1));
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // idle timer never ticks
  p_no_tick_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              msbf_i,
  input  logic              loop_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              rx_done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  eng_st_e           st_q, st_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [LEN_W-1:0]  k_q, k_d;
  logic              sclk_q, sclk_d;
  logic              done_q, done_d;
  logic [LEN_W-2:0]  pos;
  logic              smp;
  logic              last;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    k_d    = k_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    smp    = loop_i ? sh_q[0] : miso_i;
    last   = (k_q == len_i - LEN_W'(1));
    pos    = msbf_i ? (LEN_W-1)'(len_i - LEN_W'(1) - k_q) : k_q[LEN_W-2:0];
    case (st_q)
      ST_IDLE: begin
        sclk_d = 1'b0;
        if (start_i) begin
          st_d = ST_SHIFT;
          k_d  = '0;
          rx_d = '0;
          sh_d = msbf_i ? (flip_word(tx_word_i) >> (LEN_W'(WORD_W) - len_i))
                        : tx_word_i;
        end
      end
      ST_SHIFT: begin
        if (!run_i) begin
          st_d   = ST_IDLE;
          sclk_d = 1'b0;
        end else if (tick_i) begin
          if (!sclk_q) begin
            sclk_d    = 1'b1;
            rx_d[pos] = smp;
            done_d    = last;
          end else begin
            sclk_d = 1'b0;
            if (last) begin
              st_d = ST_IDLE;
            end else begin
              k_d  = k_q + LEN_W'(1);
              sh_d = sh_q >> 1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      rx_q   <= '0;
      k_q    <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      k_q    <= k_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign busy_o    = (st_q == ST_SHIFT);
  assign sclk_o    = sclk_q;
  assign mosi_o    = busy_o & sh_q[0];
  assign rx_done_o = done_q;
  assign rx_word_o = rx_q;

  p_sclk_low_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sclk_q);

  p_mosi_still_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));

  p_bit_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> (k_q < len_i));

  p_done_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(k_q) == $past(len_i) - LEN_W'(1)));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              hold_vld_o,
  input  logic              load_i,
  input  logic              rx_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              irq_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              hv_q, hv_d;
  logic              rxf_q, rxf_d, slot_q, slot_d;
  logic [1:0]        msk_q, msk_d;
  logic              wr_ctrl, wr_evt, wr_msk, wr_tx;
  logic              unused_wbits;

  assign wr_ctrl = wr_i && (addr_i == ADR_CTRL);
  assign wr_evt  = wr_i && (addr_i == ADR_EVT);
  assign wr_msk  = wr_i && (addr_i == ADR_MASK);
  assign wr_tx   = wr_i && (addr_i == ADR_TX);
  assign unused_wbits = ^{wdata_i[31], wdata_i[29:27], wdata_i[15:10]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.loop = wdata_i[B_LOOP];
      ctrl_d.msbf = wdata_i[B_MSBF];
      ctrl_d.mast = wdata_i[B_MAST];
      ctrl_d.run  = wdata_i[B_RUN];
      ctrl_d.div  = wdata_i[B_DIV +: 4];
      if (!ctrl_q.run) ctrl_d.lcode = wdata_i[B_LEN +: 4];
    end
    tx_d   = wr_tx ? wdata_i : tx_q;
    hv_d   = wr_tx | (hv_q & ~load_i);
    rx_d   = rx_done_i ? rx_word_i : rx_q;
    rxf_d  = rx_done_i | (rxf_q & ~(wr_evt & wdata_i[E_RXF]));
    if (wr_tx) slot_d = 1'b0;
    else       slot_d = load_i | (slot_q & ~(wr_evt & wdata_i[E_SLOT]));
    msk_d  = wr_msk ? {wdata_i[E_RXF], wdata_i[E_SLOT]} : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      hv_q   <= 1'b0;
      rxf_q  <= 1'b0;
      slot_q <= 1'b1;
      msk_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      hv_q   <= hv_d;
      rxf_q  <= rxf_d;
      slot_q <= slot_d;
      msk_q  <= msk_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTRL: begin
        rdata_o[B_LOOP]      = ctrl_q.loop;
        rdata_o[B_MSBF]      = ctrl_q.msbf;
        rdata_o[B_MAST]      = ctrl_q.mast;
        rdata_o[B_RUN]       = ctrl_q.run;
        rdata_o[B_LEN +: 4]  = ctrl_q.lcode;
        rdata_o[B_DIV +: 4]  = ctrl_q.div;
      end
      ADR_EVT: begin
        rdata_o[E_RXF]  = rxf_q;
        rdata_o[E_SLOT] = slot_q;
      end
      ADR_MASK: begin
        rdata_o[E_RXF]  = msk_q[1];
        rdata_o[E_SLOT] = msk_q[0];
      end
      ADR_RX:  rdata_o = rx_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign tx_word_o  = tx_q;
  assign hold_vld_o = hv_q;
  assign irq_o      = (rxf_q & msk_q[1]) | (slot_q & msk_q[0]);

  p_len_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q.run) |=> $stable(ctrl_q.lcode));

  p_rxf_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> rxf_q);

  p_slot_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_tx) |=> slot_q);

  p_slot_clr_on_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !slot_q);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int DIV_UNIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  ctrl_t             ctrl;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic              hold_vld, load, busy, tick, rx_done, active;
  logic [LEN_W-1:0]  clen;

  assign active = ctrl.run & ctrl.mast;
  assign load   = hold_vld & active & ~busy;
  assign clen   = code_to_len(ctrl.lcode);

  spi_reg_bank u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .ctrl_o     (ctrl),
    .tx_word_o  (tx_word),
    .hold_vld_o (hold_vld),
    .load_i     (load),
    .rx_done_i  (rx_done),
    .rx_word_i  (rx_word),
    .irq_o      (irq)
  );

  spi_half_timer #(.DIV_UNIT(DIV_UNIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .div_i  (ctrl.div),
    .tick_o (tick)
  );

  spi_shift_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (active),
    .start_i   (load),
    .tx_word_i (tx_word),
    .len_i     (clen),
    .msbf_i    (ctrl.msbf),
    .loop_i    (ctrl.loop),
    .miso_i    (miso),
    .tick_i    (tick),
    .busy_o    (busy),
    .sclk_o    (sclk),
    .mosi_o    (mosi),
    .rx_done_o (rx_done),
    .rx_word_o (rx_word)
  );

  p_quiet_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> !sclk);

endmodule

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, miso;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, sclk, mosi;

  spi_host_ctrl #(.DIV_UNIT(1)) i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  typedef struct {
    int          n;
    logic [31:0] bits;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0, n_bad = 0;
  bit          ended = 0;
  logic [31:0] slave_seq = '0;
  int          slave_idx = 0;
  int          rises = 0;
  int          mon_cnt = 0;
  logic [31:0] mon_bits = '0;
  int          hi_cnt = 0, last_hi = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = slave_seq[(slave_idx > 31) ? 31 : slave_idx];
  always @(negedge sclk) slave_idx++;
  always @(posedge sclk) rises++;

  always @(posedge clk) begin
    if (sclk) hi_cnt++;
    else if (hi_cnt != 0) begin
      last_hi = hi_cnt;
      hi_cnt  = 0;
    end
  end

  // monitor: collects bits seen on mosi at each rising sclk edge
  always @(posedge sclk) begin
    if (sb_q.size() != 0) begin
      mon_bits[mon_cnt] = mosi;
      mon_cnt++;
      if (mon_cnt == sb_q[0].n) begin
        check(mon_bits == sb_q[0].bits, {sb_q[0].tag, " mosi order"},
              mon_bits, sb_q[0].bits);
        mon_bits = '0;
        mon_cnt  = 0;
        void'(sb_q.pop_front());
      end
    end else begin
      check(1'b0, "R7 unexpected sclk edge", 0, 1);
    end
  end

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input bit lp, input bit msb, input bit mst,
                                     input bit en, input int code, input int dv);
    return {1'b0, lp, 3'b000, msb, mst, en, 4'(code), 4'(dv), 16'h0000};
  endfunction

  function automatic int n_of(input int code);
    if (code == 0) return 32;
    if (code <= 3) return 4;
    return code + 1;
  endfunction

  function automatic logic [31:0] lowmask(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [31:0] wire_order(input logic [31:0] d, input int n,
                                             input bit msb);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = msb ? d[n-1-i] : d[i];
    return r;
  endfunction

  function automatic logic [31:0] rx_expect(input logic [31:0] seq, input int n,
                                            input bit msb);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[msb ? n-1-i : i] = seq[i];
    return r;
  endfunction

  task automatic wait_rxf(input string tag);
    logic [31:0] ev;
    int t = 0;
    do begin
      rd(3'd1, ev);
      t++;
    end while (!ev[9] && t < 5000);
    check(ev[9] == 1'b1, {tag, " receive flag"}, ev, ev | 32'h200);
  endtask

  task automatic run_char(input bit lp, input bit msb, input int code, input int dv,
                          input logic [31:0] tx, input logic [31:0] seq,
                          input string tag);
    int n;
    exp_t e;
    logic [31:0] got, want;
    n = n_of(code);
    wr(3'd0, mk(lp, msb, 1, 0, code, dv));
    wr(3'd0, mk(lp, msb, 1, 1, code, dv));
    wr(3'd1, 32'h300);
    slave_seq = seq; slave_idx = 0; rises = 0;
    e.n = n; e.bits = wire_order(tx, n, msb); e.tag = tag;
    sb_q.push_back(e);
    wr(3'd3, tx);
    wait_rxf(tag);
    rd(3'd4, got);
    want = lp ? (tx & lowmask(n)) : rx_expect(seq, n, msb);
    check(got == want, {tag, " receive word"}, got, want);
    repeat (40) @(negedge clk);
    check(rises == n, {tag, " R3 edge count"}, rises, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] v;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check(v == 32'h0, "R1 control after reset", v, 0);
    rd(3'd1, v); check(v == 32'h100, "R1 events after reset", v, 32'h100);
    rd(3'd2, v); check(v == 32'h0, "R1 mask after reset", v, 0);
    check({irq, sclk, mosi} == 3'b000, "R1 pins after reset", {irq, sclk, mosi}, 0);

    // R2 field layout, junk bits dropped
    wr(3'd0, 32'hFEFF_FFFF);
    rd(3'd0, v); check(v == 32'h46FF_0000, "R2 control readback", v, 32'h46FF_0000);
    rd(3'd3, v); check(v == 32'h0, "R2 transmit reads zero", v, 0);
    wr(3'd0, 32'h0);

    // R3 R7 R8: length classes and both orders
    run_char(0, 0, 7, 1, 32'h0000_00A5, 32'h0000_003C, "R7 lsb 8b");
    run_char(0, 1, 0, 1, 32'h1234_5678, 32'h9ABC_DEF1, "R8 msb 32b");
    run_char(0, 1, 1, 2, 32'hFFFF_FFF6, 32'h0000_0005, "R3 code1 4b");
    run_char(0, 0, 15, 1, 32'hFFFF_C3A9, 32'h0000_6B2D, "R3 code15 16b");
    run_char(0, 1, 4, 1, 32'h0000_0013, 32'h0000_000E, "R8 msb 5b");

    // R9 loopback with miso held at each level
    run_char(1, 0, 11, 1, 32'h0000_0B5E, 32'hFFFF_FFFF, "R9 loop miso1");
    run_char(1, 1, 9, 1, 32'h0000_02C7, 32'h0000_0000, "R9 loop miso0");

    // R6 half period width
    run_char(0, 0, 7, 3, 32'h0000_005A, 32'h0, "R6 div3");
    check(last_hi == 3, "R6 high width div3", last_hi, 3);
    run_char(0, 0, 3, 0, 32'h0000_0009, 32'h0, "R6 div0");
    check(last_hi == 16, "R6 high width div0", last_hi, 16);

    // R4 length locked while enabled
    wr(3'd0, mk(0, 0, 1, 0, 7, 1));
    wr(3'd0, mk(0, 0, 1, 1, 7, 1));
    wr(3'd0, mk(0, 0, 1, 1, 12, 5));
    rd(3'd0, v);
    check(v == mk(0, 0, 1, 1, 7, 5), "R4 length kept, divider updated", v, mk(0, 0, 1, 1, 7, 5));

    // R5 held while master clear
    begin
      exp_t e;
      logic [31:0] got;
      wr(3'd0, mk(0, 0, 0, 0, 7, 1));
      wr(3'd0, mk(0, 0, 0, 1, 7, 1));
      wr(3'd1, 32'h300);
      slave_seq = 32'h0000_0066; slave_idx = 0; rises = 0;
      e.n = 8; e.bits = 32'h0000_005A; e.tag = "R5 held";
      sb_q.push_back(e);
      wr(3'd3, 32'h0000_005A);
      repeat (60) @(negedge clk);
      check(rises == 0, "R5 no sclk while master clear", rises, 0);
      rd(3'd1, v); check(v[8] == 1'b0, "R10 slot busy after write", v, v & ~32'h100);
      wr(3'd0, mk(0, 0, 1, 1, 7, 1));
      wait_rxf("R5 released");
      rd(3'd4, got);
      check(got == 32'h0000_0066, "R5 receive after release", got, 32'h66);
      repeat (40) @(negedge clk);
    end

    // R10 holding slot while a character is in flight
    begin
      exp_t e;
      wr(3'd0, mk(0, 0, 1, 0, 7, 4));
      wr(3'd0, mk(0, 0, 1, 1, 7, 4));
      wr(3'd1, 32'h300);
      slave_seq = 32'hFFFF_FFFF; slave_idx = 0; rises = 0;
      e.n = 8; e.bits = 32'h81; e.tag = "R10 first";  sb_q.push_back(e);
      e.n = 8; e.bits = 32'h7E; e.tag = "R10 second"; sb_q.push_back(e);
      wr(3'd3, 32'h81);
      repeat (3) @(negedge clk);
      rd(3'd1, v); check(v[8] == 1'b1, "R10 slot free after load", v, v | 32'h100);
      wr(3'd3, 32'h7E);
      rd(3'd1, v); check(v[8] == 1'b0, "R10 slot full while busy", v, v & ~32'h100);
      repeat (90) @(negedge clk);
      rd(3'd1, v); check(v[8] == 1'b1, "R10 slot free after second load", v, v | 32'h100);
      repeat (90) @(negedge clk);
      check(rises == 16, "R10 both characters sent", rises, 16);
    end

    // R11 write-one-to-clear
    rd(3'd1, v); check(v == 32'h300, "R11 both flags set", v, 32'h300);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check(v == 32'h300, "R11 zero write no effect", v, 32'h300);
    wr(3'd1, 32'h200);
    rd(3'd1, v); check(v == 32'h100, "R11 clear receive only", v, 32'h100);

    // R12 interrupt masking
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check(v == 32'h300, "R12 mask readback", v, 32'h300);
    wr(3'd2, 32'h200);
    @(negedge clk); check(irq == 1'b0, "R12 masked receive, flag clear", irq, 0);
    wr(3'd2, 32'h100);
    @(negedge clk); check(irq == 1'b1, "R12 slot flag raises irq", irq, 1);
    wr(3'd1, 32'h100);
    @(negedge clk); check(irq == 1'b0, "R12 irq drops after clear", irq, 0);
    wr(3'd2, 32'h0);

    check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    summary();
  end
endmodule